// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Deferred Pending

This block collects up to 32 level-sensitive interrupt sources belonging to one group and presents them as a single interrupt line. Sources are qualified by an enable word that only ever accumulates bits. The qualified set of sources is the selected word. It is latched into a status register that firmware reads to learn which sources fired. If a service routine is already running, the selected word is parked in a hidden pending register instead.

Firmware acknowledges each source by clearing its status bit. When the last status bit clears, any parked sources are replayed into status and the line stays high. Otherwise the line drops. Once a bit is enabled, a later write to the enable register no longer adds enables. It acts as a mask or unmask command for the duration of a service routine. A status write of all ones is an initialisation. It wipes status without replaying pending sources and leaves the line as it was.

Top module: `irq_group_merge`

## Requirements
- R1: After a synchronous active-low reset, the enable and status words read 0, the output is low, and the mask and pending words are empty.
- R2: The selected word is the source lines ANDed with the accumulated enable as it stood at the start of the cycle. A zero selected word changes nothing, so low or unenabled lines are ignored.
- R3: With status and mask both zero, a nonzero selected word is loaded into status and the output is high from the next cycle.
- R4: With status or mask nonzero, the selected word is ORed into pending, and status and the output keep their values.
- R5: An enable write ORs its data into the sticky accumulated enable. When this changes the accumulated value, the data is stored as the readable enable word and the mask is untouched.
- R6: An enable write of zero while the accumulated enable is zero only stores zero as the readable enable word.
- R7: Any other enable write is a mask command. The change word is the stored enable word XOR the data. If change AND data is nonzero, the changed bits leave the mask; otherwise they join it. The data is then stored.
- R8: A status write clears every written 1 bit. A status write of zero has no effect.
- R9: A status write of 0xFFFFFFFF clears status, keeps pending as it is, and leaves the output unchanged.
- R10: When a normal status clear leaves status at zero, a nonzero pending word moves into status, pending empties, and the output stays high. With no pending word, the output goes low.
- R11: Only aligned word addresses decode. The enable word is at byte offset 0x0 and status at 0x4. Other addresses read 0 and ignore writes.
- R12: Within one cycle, a status write is applied before the source evaluation. The evaluation tests the mask as left by that cycle's enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | NSRC | Level interrupt sources of the group |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Aggregated interrupt line of the group |

## Verification
A status write and a source evaluation can occur in the same cycle, and so can an enable-register mask command and a source evaluation. The bench drives both pairs on one clock edge. In the first case, a clear that empties status meets a new source pulse, and the new source must land in status with the line still high. In the second case, an enable write of zero that sets the mask meets a source pulse, and the source must go to pending. Both outcomes are judged through the status read-back and the line level, and later through the order in which the parked source is replayed.

// File: rtl/irq_merge_pkg.sv
// Package: shared register width and byte offsets of the aggregator.
// Assumes 32-bit word registers with aligned byte addressing.
package irq_merge_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned OFF_ENABLE = 0;
    localparam int unsigned OFF_STATUS = 4;
    localparam logic [REG_W-1:0] ALL_ONES = '1;
endpackage

// File: rtl/irq_src_select.sv
// Module: irq_src_select
// Forms the selected word from the source lines and the accumulated
// enable. Source bits above NSRC read as zero.
// Assumes: NSRC <= W; sources are already synchronous to clk.
module irq_src_select #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned W    = 32
) (
    input  logic [NSRC-1:0] src_lvl,
    input  logic [W-1:0]    acc_en,
    output logic [W-1:0]    sel,
    output logic            sel_hit
);
    // Per-bit qualification of each source by its enable bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < NSRC) begin : g_live
            assign sel[i] = src_lvl[i] & acc_en[i];
        end else begin : g_tied
            assign sel[i] = 1'b0;
        end
    end

    // Any qualified source triggers an evaluation this cycle.
    assign sel_hit = |sel;
endmodule

// File: rtl/irq_enable_ctrl.sv
// Module: irq_enable_ctrl
// Holds the readable enable word, the sticky accumulated enable, and
// the service mask. Decodes an enable write into an enable add or a
// mask/unmask command.
// Assumes: wr is a single-cycle strobe, already decoded for this register.
module irq_enable_ctrl #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] mask_nxt
);
    logic [W-1:0] acc_nxt;
    logic [W-1:0] en_nxt;
    logic [W-1:0] acc_or;
    logic [W-1:0] change;

    // Candidate accumulated enable and mask change word.
    assign acc_or = acc_q | wdata;
    assign change = en_q ^ wdata;

    // Next-state decode for an enable-register write.
    always_comb begin
        acc_nxt  = acc_q;
        en_nxt   = en_q;
        mask_nxt = mask_q;
        if (wr) begin
            if ((wdata == '0) && (acc_q == '0)) begin
                en_nxt = wdata;
            end else if (acc_or != acc_q) begin
                acc_nxt = acc_or;
                en_nxt  = wdata;
            end else begin
                if ((change & wdata) != '0) begin
                    mask_nxt = mask_q & ~change;
                end else begin
                    mask_nxt = mask_q | change;
                end
                en_nxt = wdata;
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            acc_q  <= acc_nxt;
            en_q   <= en_nxt;
            mask_q <= mask_nxt;
        end
    end
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: irq_status_ctrl
// Holds status, pending and the output line. A status write is applied
// first, then the source evaluation runs on the result in the same cycle.
// Assumes: mask_in is the mask as left by this cycle's enable write.
module irq_status_ctrl
    import irq_merge_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] sel,
    input  logic         sel_hit,
    input  logic [W-1:0] mask_in,
    output logic [W-1:0] status_q,
    output logic [W-1:0] pending_q,
    output logic         irq_q
);
    localparam logic [W-1:0] INIT_WORD = ALL_ONES[W-1:0];

    logic [W-1:0] st_a, pd_a;
    logic         irq_a;
    logic [W-1:0] st_n, pd_n;
    logic         irq_n;
    logic         clr_valid;
    logic         clr_init;

    assign clr_valid = wr && (wdata != '0);
    assign clr_init  = (wdata == INIT_WORD);

    // Stage one: write-one-to-clear and replay on an emptied status.
    always_comb begin
        st_a  = status_q;
        pd_a  = pending_q;
        irq_a = irq_q;
        if (clr_valid) begin
            st_a = status_q & ~wdata;
            if (!clr_init && (st_a == '0)) begin
                if (pending_q != '0) begin
                    st_a  = pending_q;
                    pd_a  = '0;
                    irq_a = 1'b1;
                end else begin
                    irq_a = 1'b0;
                end
            end
        end
    end

    // Stage two: deliver or defer the selected word.
    always_comb begin
        st_n  = st_a;
        pd_n  = pd_a;
        irq_n = irq_a;
        if (sel_hit) begin
            if ((mask_in != '0) || (st_a != '0)) begin
                pd_n = pd_a | sel;
            end else begin
                st_n  = sel;
                irq_n = 1'b1;
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= '0;
            pending_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            status_q  <= st_n;
            pending_q <= pd_n;
            irq_q     <= irq_n;
        end
    end
endmodule

// File: rtl/irq_group_merge.sv
// Module: irq_group_merge (top)
// One interrupt group: source selection, enable/mask control, and
// status/pending handling behind two word registers.
// Assumes: aligned 32-bit accesses; bus_wr lasts one cycle per write;
// the read data is combinational on bus_addr.
module irq_group_merge
    import irq_merge_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_out
);
    localparam int unsigned W = REG_W;
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(OFF_STATUS);

    logic         sel_en, sel_st;
    logic         wr_en_hit, wr_st_hit;
    logic [W-1:0] acc_q, en_q, mask_q, mask_nxt;
    logic [W-1:0] sel;
    logic         sel_hit;
    logic [W-1:0] status_q, pending_q;
    logic         irq_q;

    // Full-address decode; unaligned or unknown offsets never match.
    assign sel_en    = (bus_addr == A_EN);
    assign sel_st    = (bus_addr == A_ST);
    assign wr_en_hit = bus_wr && sel_en;
    assign wr_st_hit = bus_wr && sel_st;

    irq_src_select #(.NSRC(NSRC), .W(W)) u_sel (
        .src_lvl (src_lvl),
        .acc_en  (acc_q),
        .sel     (sel),
        .sel_hit (sel_hit)
    );

    irq_enable_ctrl #(.W(W)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_en_hit),
        .wdata    (bus_wdata),
        .acc_q    (acc_q),
        .en_q     (en_q),
        .mask_q   (mask_q),
        .mask_nxt (mask_nxt)
    );

    irq_status_ctrl #(.W(W)) u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_st_hit),
        .wdata     (bus_wdata),
        .sel       (sel),
        .sel_hit   (sel_hit),
        .mask_in   (mask_nxt),
        .status_q  (status_q),
        .pending_q (pending_q),
        .irq_q     (irq_q)
    );

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_en) bus_rdata = en_q;
        if (sel_st) bus_rdata = status_q;
    end

    assign irq_out = irq_q;
endmodule

// Checker: temporal properties of the aggregator, bound to the top.
module irq_group_merge_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq_out,
    input logic         wr_en,
    input logic         wr_st,
    input logic [W-1:0] wdata,
    input logic [W-1:0] sel,
    input logic [W-1:0] acc_q,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] mask_nxt,
    input logic [W-1:0] status_q,
    input logic [W-1:0] pending_q
);
    // R1: reset drives the line low.
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

    // R3: idle group latches the selected word and raises the line.
    p_idle_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !wr_st && status_q == '0 && mask_q == '0 && sel != '0)
        |=> (status_q == $past(sel)) && irq_out);

    // R4: a busy group parks the source and holds status.
    p_busy_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !wr_st && status_q != '0 && sel != '0)
        |=> $stable(status_q) && irq_out
            && ((pending_q & $past(sel)) == $past(sel)));

    // R5: the accumulated enable never loses a bit.
    p_sticky_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

    // R8: a zero status write with no source event changes nothing.
    p_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && wdata == '0 && sel == '0)
        |=> $stable(status_q) && $stable(pending_q) && $stable(irq_out));

    // R9: the initialisation write keeps the line and pending.
    p_init_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && wdata == '1 && sel == '0)
        |=> (status_q == '0) && $stable(irq_out) && $stable(pending_q));

    // R10: nonzero status always comes with a high line.
    p_status_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0) |-> irq_out);

    // R12: an emptying clear meets a source in the same cycle.
    p_same_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && wdata != '0 && wdata != '1 && (status_q & ~wdata) == '0
         && pending_q == '0 && sel != '0 && mask_nxt == '0)
        |=> (status_q == $past(sel)) && irq_out);
endmodule

bind irq_group_merge irq_group_merge_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .wr_en     (wr_en_hit),
    .wr_st     (wr_st_hit),
    .wdata     (bus_wdata),
    .sel       (sel),
    .acc_q     (acc_q),
    .mask_q    (mask_q),
    .mask_nxt  (mask_nxt),
    .status_q  (status_q),
    .pending_q (pending_q)
);

// File: tb/irq_group_merge_bench.sv
`timescale 1ns/100ps
module irq_group_merge_bench;
    localparam int NSRC = 32;
    localparam int AW   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_lvl = '0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    irq_group_merge #(.NSRC(NSRC), .ADDR_W(AW)) u_irq_group_merge (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] s);
        @(negedge clk); src_lvl = s[NSRC-1:0];
        @(negedge clk); src_lvl = '0;
    endtask

    task automatic wr_pulse(input logic [AW-1:0] a, input logic [31:0] d, input logic [31:0] s);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d; src_lvl = s[NSRC-1:0];
        @(negedge clk); bus_wr = 1'b0; src_lvl = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk); bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string tag, input logic exp);
        @(negedge clk); #1;
        chk(tag, {31'b0, irq_out}, {31'b0, exp});
    endtask

    // R1, R6, R2: reset state, zero enable on empty accumulator, no enables.
    task automatic t_reset;
        rd_chk("R1 enable after reset", 4'h0, 32'h0);
        rd_chk("R1 status after reset", 4'h4, 32'h0);
        irq_chk("R1 line after reset", 1'b0);
        wr(4'h0, 32'h0);
        rd_chk("R6 zero enable stored", 4'h0, 32'h0);
        pulse(32'h1);
        rd_chk("R2 unenabled source ignored", 4'h4, 32'h0);
        irq_chk("R2 line stays low", 1'b0);
    endtask

    // R5, R2, R3, R4, R8, R10: basic delivery, deferral and replay.
    task automatic t_deliver;
        wr(4'h0, 32'h0000_00FF);
        rd_chk("R5 enable stored", 4'h0, 32'h0000_00FF);
        pulse(32'h0000_0F03);
        rd_chk("R3 status loaded with selected word (R2)", 4'h4, 32'h3);
        irq_chk("R3 line high", 1'b1);
        pulse(32'h0000_000C);
        rd_chk("R4 status held while busy", 4'h4, 32'h3);
        wr(4'h4, 32'h1);
        rd_chk("R8 one bit cleared", 4'h4, 32'h2);
        wr(4'h4, 32'h0);
        rd_chk("R8 zero write ignored", 4'h4, 32'h2);
        wr(4'h4, 32'h2);
        rd_chk("R10 pending replayed", 4'h4, 32'hC);
        irq_chk("R10 line stays high on replay", 1'b1);
        wr(4'h4, 32'hC);
        rd_chk("R10 status empty", 4'h4, 32'h0);
        irq_chk("R10 line low with no pending", 1'b0);
    endtask

    // R7: mask and unmask commands through the enable register.
    task automatic t_mask;
        wr(4'h0, 32'h0000_00FE);
        rd_chk("R7 mask command stores data", 4'h0, 32'h0000_00FE);
        pulse(32'h10);
        rd_chk("R7 masked source deferred (R4)", 4'h4, 32'h0);
        irq_chk("R7 line low while masked", 1'b0);
        wr(4'h0, 32'h0000_00FF);
        pulse(32'h20);
        rd_chk("R7 unmasked delivery", 4'h4, 32'h20);
        wr(4'h4, 32'h20);
        rd_chk("R7 masked source replayed", 4'h4, 32'h10);
        wr(4'h4, 32'h10);
        irq_chk("R7 line low after drain", 1'b0);
        wr(4'h0, 32'h0);
        rd_chk("R7 zero enable write stored", 4'h0, 32'h0);
        pulse(32'h1);
        rd_chk("R7 zero write masked all", 4'h4, 32'h0);
        wr(4'h0, 32'h0000_00FF);
        pulse(32'h2);
        rd_chk("R7 unmask all then deliver", 4'h4, 32'h2);
        wr(4'h4, 32'h2);
        rd_chk("R7 parked source follows", 4'h4, 32'h1);
        wr(4'h4, 32'h1);
        irq_chk("R7 drained", 1'b0);
    endtask

    // R9: initialisation clear keeps pending and the line.
    task automatic t_init;
        pulse(32'h1);
        pulse(32'h2);
        wr(4'h4, 32'hFFFF_FFFF);
        rd_chk("R9 status wiped", 4'h4, 32'h0);
        irq_chk("R9 line unchanged", 1'b1);
        pulse(32'h4);
        rd_chk("R9 new source loads", 4'h4, 32'h4);
        wr(4'h4, 32'h4);
        rd_chk("R9 pending survived init", 4'h4, 32'h2);
        wr(4'h4, 32'h2);
        irq_chk("R9 drained", 1'b0);
    endtask

    // R5, R11: sticky enable and address decode.
    task automatic t_sticky_addr;
        wr(4'h0, 32'h0000_0100);
        rd_chk("R5 new enable stored", 4'h0, 32'h0000_0100);
        pulse(32'h1);
        rd_chk("R5 old enable still active", 4'h4, 32'h1);
        wr(4'h4, 32'h1);
        wr(4'h8, 32'h1234_5678);
        rd_chk("R11 unmapped reads zero", 4'h8, 32'h0);
        wr(4'h1, 32'hDEAD_BEEF);
        rd_chk("R11 unaligned write ignored", 4'h0, 32'h0000_0100);
        irq_chk("R11 line low", 1'b0);
    endtask

    // R12: same-cycle write and source evaluation.
    task automatic t_same_cycle;
        pulse(32'h1);
        wr_pulse(4'h4, 32'h1, 32'h2);
        rd_chk("R12 clear then deliver", 4'h4, 32'h2);
        irq_chk("R12 line high", 1'b1);
        wr(4'h4, 32'h2);
        wr_pulse(4'h0, 32'h0, 32'h4);
        rd_chk("R12 same-cycle mask defers", 4'h4, 32'h0);
        wr(4'h0, 32'h0000_0100);
        pulse(32'h8);
        rd_chk("R12 delivered after unmask", 4'h4, 32'h8);
        wr(4'h4, 32'h8);
        rd_chk("R12 deferred source replayed", 4'h4, 32'h4);
        wr(4'h4, 32'h4);
        irq_chk("R12 drained", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_deliver();
        t_mask();
        t_init();
        t_sticky_addr();
        t_same_cycle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule